// File: doc/BRIEF.md
# Masked Vector Register Writeback Unit

This block works out the new value of a 512-bit vector destination for a packed move of 32-bit elements. It receives the source vector, the current destination contents, a 16-bit lane mask and the control fields of the move. These fields are the vector length, the encoding class, masking on or off, zeroing or merging, load/register form or store form, and a 4-bit spare register specifier. From them it produces the full destination value. For store form it also produces one write-enable bit per lane, so that a memory port can perform a partial write.

The encoding class decides two things. It decides whether the lane mask is honoured: only the masked class uses it, and the other two classes act as if every mask bit were set. It also decides what happens to destination bits above the vector length. In load form the wide and masked classes clear those bits, while the base class leaves them as they were. A store never changes anything above the vector length.

Illegal field combinations raise an undefined-opcode flag. In that case the destination is left as it was and no lane is enabled. The block has no arithmetic. The result and its flags are registered one clock edge after a valid input.

Top module: `vreg_mask_wb`

## Requirements
- R1: Once reset (synchronous, active low) has been applied, `out_valid`, `result_vec`, `lane_we` and `undef_op` are all zero.
- R2: `out_valid` goes high exactly one clock edge after a cycle with `in_valid` high, and goes low one edge after a cycle with `in_valid` low. `result_vec`, `lane_we` and `undef_op` are loaded on that same edge.
- R3: Lane j occupies bits 32j+31:32j. `vlen_code` 0, 1 and 2 select 128, 256 and 512 bits, which is 4, 8 and 16 lanes. Without masking, every lane below the length takes the source lane. Masking is off when the class is base (`enc_class`=0) or wide (1), or when the class is masked (2) with `mask_en` low. The base and wide classes ignore `lane_mask`, `mask_en` and `zero_mode`.
- R4: Masked class, `mask_en` high, `zero_mode` low, load form (`store_form`=0): a lane below the length whose `lane_mask` bit is 0 keeps its old destination value.
- R5: As in R4 but with `zero_mode` high: such a lane becomes zero.
- R6: Load form: bits from the vector length up to 511 are zero for the wide and masked classes, and keep their old value for the base class. Mask bits above the length have no effect.
- R7: Store form (`store_form`=1): a lane takes the source when it is below the length and its effective mask bit is set. Every other lane, including all lanes above the length, keeps its old value. `lane_we` equals the set of lanes that take the source. `zero_mode` has no effect.
- R8: In load form `lane_we` is all zero.
- R9: For the wide and masked classes, any `spare_spec` value other than 4'b1111 sets `undef_op`. The base class ignores `spare_spec`.
- R10: `undef_op` is also set for `enc_class`=3, for `vlen_code`=3, for the base class with any length other than 128, and for the wide class with length 512.
- R11: When `undef_op` is set, `result_vec` equals the old destination and `lane_we` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid this cycle |
| src_vec | input | 512 | Source vector |
| old_dst | input | 512 | Current destination contents |
| lane_mask | input | 16 | Per-lane mask, bit j for lane j |
| vlen_code | input | 2 | 0=128, 1=256, 2=512, 3 reserved |
| enc_class | input | 2 | 0=base, 1=wide, 2=masked, 3 reserved |
| mask_en | input | 1 | Masking requested (masked class only) |
| zero_mode | input | 1 | 1=zeroing, 0=merging for masked-off lanes |
| store_form | input | 1 | 1=store form, 0=load/register form |
| spare_spec | input | 4 | Spare register specifier, must be all ones for wide/masked |
| out_valid | output | 1 | Registered result valid |
| result_vec | output | 512 | New destination value |
| lane_we | output | 16 | Per-lane write enable for store targets |
| undef_op | output | 1 | Undefined-opcode flag |

## Verification
Every source lane and old lane carries a word that encodes its lane index and the vector number. Because of this, a lane taken from the wrong side, from the wrong index, or from a zero shows up as a mismatch. Irregular masks are applied in merging, zeroing and store modes to tell the three hole behaviours apart. The same length is run under each encoding class to separate clearing from keeping the bits above the length. Each illegal combination, and the spare-specifier value, is tried on its own to show that every undefined case keeps the old value. Back-to-back requests and a reset in the middle of the run pin down the one-edge latency and the cleared state.

// File: rtl/vreg_mask_wb_pkg.sv
// Shared types and helpers for the masked vector writeback unit.
// Assumes the full vector is divided into four quarter-length steps.
package vreg_mask_wb_pkg;

    typedef enum logic [1:0] {
        ENC_BASE   = 2'd0,
        ENC_WIDE   = 2'd1,
        ENC_MASKED = 2'd2,
        ENC_RSVD   = 2'd3
    } enc_cls_e;

    typedef enum logic [1:0] {
        LEN_QUARTER = 2'd0,
        LEN_HALF    = 2'd1,
        LEN_FULL    = 2'd2,
        LEN_RSVD    = 2'd3
    } vlen_e;

    // Number of lanes covered by a length code, given the full lane count.
    function automatic int unsigned active_lanes(vlen_e v, int unsigned full);
        case (v)
            LEN_QUARTER: return full / 4;
            LEN_HALF:    return full / 2;
            LEN_FULL:    return full;
            default:     return 0;
        endcase
    endfunction

endpackage

// File: rtl/vreg_mask_wb_ctrl.sv
// Decodes the control fields of one move into per-lane enables and flags.
// Assumes: only the masked class honours the lane mask, and the base
// class supports the quarter length only.
module vreg_mask_wb_ctrl
    import vreg_mask_wb_pkg::*;
#(
    parameter int unsigned LANES  = 16,
    parameter int unsigned SPEC_W = 4
) (
    input  logic [1:0]        enc_class,
    input  logic [1:0]        vlen_code,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [SPEC_W-1:0] spare_spec,
    output logic [LANES-1:0]  len_en,
    output logic [LANES-1:0]  take_en,
    output logic              zero_hole,
    output logic              keep_upper,
    output logic              undef
);

    enc_cls_e    enc;
    vlen_e       vlen;
    int unsigned n_lanes;
    logic        mask_on;

    assign enc     = enc_cls_e'(enc_class);
    assign vlen    = vlen_e'(vlen_code);
    assign n_lanes = active_lanes(vlen, LANES);

    // Lane-in-length enables, one per lane.
    for (genvar j = 0; j < LANES; j++) begin : g_len
        assign len_en[j] = (j < n_lanes);
    end

    // Masking state and the effective lane selection.
    always_comb begin
        mask_on    = (enc == ENC_MASKED) && mask_en;
        take_en    = len_en & (mask_on ? lane_mask : {LANES{1'b1}});
        zero_hole  = mask_on && zero_mode;
        keep_upper = (enc == ENC_BASE);
    end

    // Illegal-combination detection.
    always_comb begin
        undef = 1'b0;
        if (enc == ENC_RSVD || vlen == LEN_RSVD)          undef = 1'b1;
        if (enc == ENC_BASE && vlen != LEN_QUARTER)       undef = 1'b1;
        if (enc == ENC_WIDE && vlen == LEN_FULL)          undef = 1'b1;
        if (enc != ENC_BASE && spare_spec != {SPEC_W{1'b1}}) undef = 1'b1;
    end

endmodule

// File: rtl/vreg_mask_wb_lane.sv
// Selects the new value of one element lane and its store write enable.
// Assumes take_en already includes the length and the effective mask.
module vreg_mask_wb_lane #(
    parameter int unsigned ELEM_W = 32
) (
    input  logic [ELEM_W-1:0] src,
    input  logic [ELEM_W-1:0] old,
    input  logic              in_len,
    input  logic              take,
    input  logic              zero_hole,
    input  logic              keep_upper,
    input  logic              store_form,
    output logic [ELEM_W-1:0] res,
    output logic              we
);

    // Per-lane choice among source, old value and zero.
    always_comb begin
        if (take)            res = src;
        else if (store_form) res = old;
        else if (in_len)     res = zero_hole ? '0 : old;
        else                 res = keep_upper ? old : '0;
        we = store_form && take;
    end

endmodule

// File: rtl/vreg_mask_wb.sv
// Top of the masked vector writeback unit: per-lane selection and one
// output register stage. Assumes the full width is LANES * ELEM_W.
module vreg_mask_wb #(
    parameter int unsigned ELEM_W = 32,
    parameter int unsigned LANES  = 16,
    parameter int unsigned SPEC_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [LANES*ELEM_W-1:0]  src_vec,
    input  logic [LANES*ELEM_W-1:0]  old_dst,
    input  logic [LANES-1:0]         lane_mask,
    input  logic [1:0]               vlen_code,
    input  logic [1:0]               enc_class,
    input  logic                     mask_en,
    input  logic                     zero_mode,
    input  logic                     store_form,
    input  logic [SPEC_W-1:0]        spare_spec,
    output logic                     out_valid,
    output logic [LANES*ELEM_W-1:0]  result_vec,
    output logic [LANES-1:0]         lane_we,
    output logic                     undef_op
);

    localparam int unsigned VEC_W = LANES * ELEM_W;

    logic [LANES-1:0] len_en;
    logic [LANES-1:0] take_en;
    logic             zero_hole;
    logic             keep_upper;
    logic             undef;
    logic [VEC_W-1:0] nxt_vec;
    logic [LANES-1:0] nxt_we;

    vreg_mask_wb_ctrl #(
        .LANES  (LANES),
        .SPEC_W (SPEC_W)
    ) u_ctrl (
        .enc_class  (enc_class),
        .vlen_code  (vlen_code),
        .mask_en    (mask_en),
        .zero_mode  (zero_mode),
        .lane_mask  (lane_mask),
        .spare_spec (spare_spec),
        .len_en     (len_en),
        .take_en    (take_en),
        .zero_hole  (zero_hole),
        .keep_upper (keep_upper),
        .undef      (undef)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        vreg_mask_wb_lane #(
            .ELEM_W (ELEM_W)
        ) u_lane (
            .src        (src_vec[j*ELEM_W +: ELEM_W]),
            .old        (old_dst[j*ELEM_W +: ELEM_W]),
            .in_len     (len_en[j]),
            .take       (take_en[j]),
            .zero_hole  (zero_hole),
            .keep_upper (keep_upper),
            .store_form (store_form),
            .res        (nxt_vec[j*ELEM_W +: ELEM_W]),
            .we         (nxt_we[j])
        );
    end

    // Output register: loads on a valid request, undefined keeps old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result_vec <= '0;
            lane_we    <= '0;
            undef_op   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result_vec <= undef ? old_dst : nxt_vec;
                lane_we    <= undef ? '0 : nxt_we;
                undef_op   <= undef;
            end
        end
    end

endmodule

// File: rtl/vreg_mask_wb_chk.sv
// Property checker for the writeback unit, attached by bind below.
module vreg_mask_wb_chk #(
    parameter int unsigned ELEM_W = 32,
    parameter int unsigned LANES  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    store_form,
    input logic [1:0]              enc_class,
    input logic [1:0]              vlen_code,
    input logic [LANES*ELEM_W-1:0] old_dst,
    input logic                    out_valid,
    input logic [LANES*ELEM_W-1:0] result_vec,
    input logic [LANES-1:0]        lane_we,
    input logic                    undef_op
);

    localparam int unsigned VEC_W = LANES * ELEM_W;
    localparam int unsigned QW    = VEC_W / 4;
    localparam int unsigned QL    = LANES / 4;

    // R2: valid follows the request by one edge
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: load form never enables a lane write
    a_r8_load_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !store_form) |=> (lane_we == '0));

    // R11: an undefined request enables no lane and keeps the old value
    a_r11_undef_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        undef_op |-> (lane_we == '0));
    a_r11_undef_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!undef_op || result_vec == $past(old_dst)));

    // R6: wide class, quarter length load clears everything above
    a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !store_form && enc_class == 2'd1 && vlen_code == 2'd0)
        |=> (undef_op || result_vec[VEC_W-1:QW] == '0));

    // R7: a quarter-length store enables no lane above the length
    a_r7_we_in_len: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && store_form && vlen_code == 2'd0)
        |=> (lane_we[LANES-1:QL] == '0));

endmodule

bind vreg_mask_wb vreg_mask_wb_chk #(
    .ELEM_W (ELEM_W),
    .LANES  (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .store_form (store_form),
    .enc_class  (enc_class),
    .vlen_code  (vlen_code),
    .old_dst    (old_dst),
    .out_valid  (out_valid),
    .result_vec (result_vec),
    .lane_we    (lane_we),
    .undef_op   (undef_op)
);

// File: tb/vreg_mask_wb_test.sv
module vreg_mask_wb_test;

    localparam int CLK_PERIOD = 10;
    localparam int EW = 32;
    localparam int NL = 16;
    localparam int VW = EW * NL;
    localparam int WATCHDOG = 20000;

    typedef struct packed {
        logic [1:0]  enc;
        logic [1:0]  vlen;
        logic        me;
        logic        zm;
        logic        st;
        logic [3:0]  spec;
        logic [15:0] mask;
        logic [7:0]  seed;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TABLE [NV] = '{
        '{2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 4'h0, 16'h0000, 8'h01, 4'd3},  // R3 base ignores mask/spec
        '{2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 4'hF, 16'h0000, 8'h02, 4'd3},  // R3 wide ignores mask
        '{2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 4'hF, 16'h0000, 8'h03, 4'd3},  // R3 masked class, mask off
        '{2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 4'hF, 16'hA5C3, 8'h04, 4'd4},  // R4 merging
        '{2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 4'hF, 16'hFF3C, 8'h05, 4'd5},  // R5 zeroing
        '{2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 4'hF, 16'hFFF5, 8'h06, 4'd6},  // R6 masked clears upper
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF, 16'hFFFF, 8'h07, 4'd6},  // R6 base keeps upper
        '{2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 4'hF, 16'h1234, 8'h08, 4'd7},  // R7 masked store, zero ignored
        '{2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 4'hF, 16'h0000, 8'h09, 4'd7},  // R7 wide store
        '{2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 4'hF, 16'h0000, 8'h0A, 4'd7},  // R7 short store
        '{2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 4'hE, 16'h0000, 8'h0B, 4'd9},  // R9 wide bad spec
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 4'h3, 16'h0000, 8'h0C, 4'd9},  // R9 base ignores spec
        '{2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 4'h7, 16'hFFFF, 8'h0D, 4'd9},  // R9 masked bad spec
        '{2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 8'h0E, 4'd10}, // R10 reserved class
        '{2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 8'h0F, 4'd10}, // R10 reserved length
        '{2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 8'h10, 4'd10}, // R10 base at 256
        '{2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 4'hF, 16'h0000, 8'h11, 4'd10}  // R10 wide at 512
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] old_dst = '0;
    logic [15:0]   lane_mask = '0;
    logic [1:0]    vlen_code = '0;
    logic [1:0]    enc_class = '0;
    logic          mask_en = 1'b0;
    logic          zero_mode = 1'b0;
    logic          store_form = 1'b0;
    logic [3:0]    spare_spec = '0;
    logic          out_valid;
    logic [VW-1:0] result_vec;
    logic [15:0]   lane_we;
    logic          undef_op;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    vreg_mask_wb uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .old_dst(old_dst), .lane_mask(lane_mask), .vlen_code(vlen_code),
        .enc_class(enc_class), .mask_en(mask_en), .zero_mode(zero_mode),
        .store_form(store_form), .spare_spec(spare_spec), .out_valid(out_valid),
        .result_vec(result_vec), .lane_we(lane_we), .undef_op(undef_op)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [VW-1:0] fill(input logic [7:0] salt, input logic [7:0] seed);
        logic [VW-1:0] v;
        for (int j = 0; j < NL; j++) v[j*EW +: EW] = {salt, seed, 8'(j), 8'(seed + 8'(j) + 8'd1)};
        return v;
    endfunction

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected destination, enables and flag, written from the requirements.
    task automatic model(input vec_t t, input logic [VW-1:0] s, input logic [VW-1:0] o,
                         output logic [VW-1:0] r, output logic [15:0] w, output logic u);
        int n;
        n = (t.vlen == 2'd0) ? 4 : (t.vlen == 2'd1) ? 8 : 16;
        u = (t.enc == 2'd3) || (t.vlen == 2'd3) || (t.enc == 2'd0 && t.vlen != 2'd0) ||
            (t.enc == 2'd1 && t.vlen == 2'd2) || (t.enc != 2'd0 && t.spec != 4'hF);
        r = o;
        w = '0;
        if (!u) begin
            for (int j = 0; j < NL; j++) begin
                logic m;
                m = (t.enc == 2'd2 && t.me) ? t.mask[j] : 1'b1;
                if (t.st) begin
                    if (j < n && m) begin r[j*EW +: EW] = s[j*EW +: EW]; w[j] = 1'b1; end
                end else if (j < n) begin
                    if (m) r[j*EW +: EW] = s[j*EW +: EW];
                    else if (t.zm) r[j*EW +: EW] = '0;
                end else if (t.enc != 2'd0) begin
                    r[j*EW +: EW] = '0;
                end
            end
        end
    endtask

    task automatic drive(input vec_t t);
        src_vec    = fill(8'h5A, t.seed);
        old_dst    = fill(8'hC3, t.seed);
        lane_mask  = t.mask;
        vlen_code  = t.vlen;
        enc_class  = t.enc;
        mask_en    = t.me;
        zero_mode  = t.zm;
        store_form = t.st;
        spare_spec = t.spec;
        in_valid   = 1'b1;
    endtask

    initial begin
        logic [VW-1:0] er;
        logic [15:0]   ew;
        logic          eu;
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk("R1 out_valid", VW'(out_valid), '0);
        chk("R1 result", result_vec, '0);
        chk("R1 lane_we", VW'(lane_we), '0);
        chk("R1 undef", VW'(undef_op), '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: no request, no valid
        chk("R2 idle", VW'(out_valid), '0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d row %0d", TABLE[i].req, i);
            drive(TABLE[i]);
            model(TABLE[i], src_vec, old_dst, er, ew, eu);
            @(negedge clk);
            in_valid = 1'b0;
            chk({tag, " valid"}, VW'(out_valid), VW'(1'b1));
            chk({tag, " result"}, result_vec, er);
            chk({tag, " we"}, VW'(lane_we), VW'(ew));
            chk({tag, " undef"}, VW'(undef_op), VW'(eu));
            if (eu) begin
                // R11: undefined keeps old value, no enables
                chk("R11 keep", result_vec, old_dst);
                chk("R11 we", VW'(lane_we), '0);
            end
            // R8: load form leaves enables clear
            if (!TABLE[i].st) chk("R8 load we", VW'(lane_we), '0);
        end

        // R2: back-to-back requests, each result one edge later
        drive(TABLE[3]);
        @(negedge clk);
        model(TABLE[3], src_vec, old_dst, er, ew, eu);
        chk("R2 first", result_vec, er);
        drive(TABLE[7]);
        model(TABLE[7], src_vec, old_dst, er, ew, eu);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 second", result_vec, er);
        chk("R2 second we", VW'(lane_we), VW'(ew));
        @(negedge clk);
        chk("R2 valid drops", VW'(out_valid), '0);

        // R1: reset in mid-run clears the outputs
        drive(TABLE[12]);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid result", result_vec, '0);
        chk("R1 mid undef", VW'(undef_op), '0);
        chk("R1 mid valid", VW'(out_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule